// File: doc/BRIEF.md
# Drive Indicator Blink Pattern Generator

This block sets the on/off level of three indicator lamps (activity, locate, fault) for each of four storage drives. A 32-bit drive control word gives one control byte per drive. A rate byte configures two shared blink sources, A and B. Each indicator has a mode code that selects one of these levels:

- off
- steady on
- a blink from source A, starting with either the lit half or the dark half
- a blink from source B, starting with either the lit half or the dark half (activity and fault only)

Time is measured in sixteenth-second sub-ticks. A parameterised divider of the system clock produces these sub-ticks. Every blink has a 50% duty cycle. The full blink period is (n+1)/8 s for a rate value n.

The twelve lamp levels are registered. A serial shifter or an LED driver downstream can therefore sample them directly. Writing the rate byte restarts both sources at the start of their lit half. This lets software line up the two sources with a known phase.

Top module: `drive_led_blinker`

## Requirements
- R1: For a rate value n (0..15), each half of a blink lasts exactly (n+1) sub-ticks, which is (n+1)*SUB_TICK_DIV clock cycles. The lit half and the dark half have the same length.
- R2: The rate of source A is `blink_rates[3:0]` and the rate of source B is `blink_rates[7:4]`. These are bits 11:8 and 15:12 of the configuration word. The two sources run independently.
- R3: Drive d uses bits [8*(3-d)+7 : 8*(3-d)] of `xmit_word`, so drive 0 uses the most significant byte. Within a drive byte, bits 7:5 are the activity mode, bits 4:3 are the locate mode and bits 2:0 are the fault mode.
- R4: For activity and fault, mode 0 drives the lamp low and mode 1 drives it high.
- R5: For activity and fault, mode 2 follows source A starting with the lit half, and mode 3 follows source A starting with the dark half. Modes 2 and 3 are therefore complements of each other at any instant.
- R6: For activity and fault, mode 6 follows source B starting with the lit half, and mode 7 follows source B starting with the dark half.
- R7: For activity and fault, modes 4 and 5 are reserved and drive the lamp low.
- R8: The locate mode has 2 bits: 0 off, 1 on, 2 source A lit-first, 3 source A dark-first.
- R9: A pulse on `blink_wr` loads both rates. Both sources restart at the first half of a fresh interval, so a lit-first lamp is high two cycles after the pulse.
- R10: While `rst` is high, all lamp outputs are low, the counters clear, and both sources return to the first half.
- R11: A change on `xmit_word` appears on the lamp outputs one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| blink_rates | input | 8 | Rate byte: A in [3:0], B in [7:4] |
| blink_wr | input | 1 | Load strobe for blink_rates; restarts both sources |
| xmit_word | input | 32 | Per-drive control bytes, drive 0 in the top byte |
| led_act | output | 4 | Activity lamp level per drive (bit d = drive d) |
| led_loc | output | 4 | Locate lamp level per drive |
| led_err | output | 4 | Fault lamp level per drive |

## Verification
Every one of the eight activity/fault codes and the four locate codes is applied to each drive in turn, with all other drives held at zero. This separates the byte placement of each drive from the field placement inside a byte, and separates the reserved codes from the blinking codes.

The mode sweep runs just after a rate write with both rates at 15, so both sources are known to be in their first half. Under that condition the lit-first and dark-first codes of the same source must give opposite levels.

Half-cycle lengths are measured on the lamp pins for rates 0, 7 and 15. In a separate run, A and B are given different rates at the same time, which shows whether the two rate nibbles are swapped or shared. A rate write made during a dark half, and a reset applied while every lamp is lit, show the restart behaviour and the reset behaviour.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int CTRL_BYTE_W = 8;

  typedef enum logic [2:0] {
    AE_OFF      = 3'd0,
    AE_ON       = 3'd1,
    AE_A_LIT1ST = 3'd2,
    AE_A_DRK1ST = 3'd3,
    AE_RSV4     = 3'd4,
    AE_RSV5     = 3'd5,
    AE_B_LIT1ST = 3'd6,
    AE_B_DRK1ST = 3'd7
  } ae_mode_e;

  typedef enum logic [1:0] {
    LC_OFF      = 2'd0,
    LC_ON       = 2'd1,
    LC_A_LIT1ST = 2'd2,
    LC_A_DRK1ST = 2'd3
  } lc_mode_e;

  // phase 0 = first half of the interval
  function automatic logic ae_level(input logic [2:0] code, input logic ph_a,
                                    input logic ph_b);
    case (ae_mode_e'(code))
      AE_ON:       return 1'b1;
      AE_A_LIT1ST: return ~ph_a;
      AE_A_DRK1ST: return ph_a;
      AE_B_LIT1ST: return ~ph_b;
      AE_B_DRK1ST: return ph_b;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic lc_level(input logic [1:0] code, input logic ph_a);
    case (lc_mode_e'(code))
      LC_ON:       return 1'b1;
      LC_A_LIT1ST: return ~ph_a;
      LC_A_DRK1ST: return ph_a;
      default:     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/led_subtick_div.sv
module led_subtick_div #(
  parameter int DIV = 3125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (cnt_q == LAST);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_blink_src.sv
module led_blink_src #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              tick,
  output logic              phase
);
  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      cnt_q  <= '0;
      phase  <= 1'b0;
    end else if (load) begin
      rate_q <= rate_in;
      cnt_q  <= '0;
      phase  <= 1'b0;
    end else if (tick) begin
      if (cnt_q == rate_q) begin
        cnt_q <= '0;
        phase <= ~phase;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_drive_dec.sv
module led_drive_dec
  import led_blink_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CTRL_BYTE_W-1:0] ctrl,
  input  logic                   ph_a,
  input  logic                   ph_b,
  output logic                   act,
  output logic                   loc,
  output logic                   err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      loc <= 1'b0;
      err <= 1'b0;
    end else begin
      act <= ae_level(ctrl[7:5], ph_a, ph_b);
      loc <= lc_level(ctrl[4:3], ph_a);
      err <= ae_level(ctrl[2:0], ph_a, ph_b);
    end
  end
endmodule

// File: rtl/drive_led_blinker.sv
module drive_led_blinker
  import led_blink_pkg::*;
#(
  parameter int NUM_DRIVES   = 4,
  parameter int RATE_W       = 4,
  parameter int SUB_TICK_DIV = 3125000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [2*RATE_W-1:0]               blink_rates,
  input  logic                              blink_wr,
  input  logic [NUM_DRIVES*CTRL_BYTE_W-1:0] xmit_word,
  output logic [NUM_DRIVES-1:0]             led_act,
  output logic [NUM_DRIVES-1:0]             led_loc,
  output logic [NUM_DRIVES-1:0]             led_err
);
  localparam int NUM_SRC = 2;

  logic               sub_tick;
  logic [NUM_SRC-1:0] src_phase;

  led_subtick_div #(.DIV(SUB_TICK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (sub_tick)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    led_blink_src #(.RATE_W(RATE_W)) u_src (
      .clk     (clk),
      .rst     (rst),
      .load    (blink_wr),
      .rate_in (blink_rates[s*RATE_W +: RATE_W]),
      .tick    (sub_tick),
      .phase   (src_phase[s])
    );
  end

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    led_drive_dec u_dec (
      .clk  (clk),
      .rst  (rst),
      .ctrl (xmit_word[CTRL_BYTE_W*(NUM_DRIVES-1-d) +: CTRL_BYTE_W]),
      .ph_a (src_phase[0]),
      .ph_b (src_phase[1]),
      .act  (led_act[d]),
      .loc  (led_loc[d]),
      .err  (led_err[d])
    );
  end
endmodule

// File: rtl/drive_led_blinker_chk.sv
module drive_led_blinker_chk #(
  parameter int NUM_DRIVES = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      blink_wr,
  input logic [NUM_DRIVES*8-1:0]   xmit_word,
  input logic [NUM_DRIVES-1:0]     led_act,
  input logic [NUM_DRIVES-1:0]     led_loc,
  input logic [NUM_DRIVES-1:0]     led_err
);
  localparam int TOP = NUM_DRIVES*8 - 1;

  // R10: reset forces every lamp low
  p_rst_dark_r10: assert property (@(posedge clk)
    rst |=> (led_act == '0 && led_loc == '0 && led_err == '0));

  // R4: steady-on code on drive 0 activity
  p_act_on_r4: assert property (@(posedge clk) disable iff (rst)
    (xmit_word[TOP -: 3] == 3'd1) |=> led_act[0]);

  // R4: off code on drive 0 fault
  p_err_off_r4: assert property (@(posedge clk) disable iff (rst)
    (xmit_word[TOP-5 -: 3] == 3'd0) |=> !led_err[0]);

  // R7: reserved codes stay dark
  p_rsv_dark_r7: assert property (@(posedge clk) disable iff (rst)
    (xmit_word[TOP -: 3] == 3'd4 || xmit_word[TOP -: 3] == 3'd5) |=> !led_act[0]);

  // R5: lit-first and dark-first of source A are complementary
  p_a_compl_r5: assert property (@(posedge clk) disable iff (rst)
    (xmit_word[TOP -: 3] == 3'd2 && xmit_word[TOP-8 -: 3] == 3'd3)
      |=> (led_act[0] != led_act[1]));

  // R9: rate write restarts at the lit half
  p_restart_lit_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(blink_wr) && !$past(rst) && $past(xmit_word[TOP -: 3]) == 3'd2 &&
     xmit_word[TOP -: 3] == 3'd2) |=> led_act[0]);

  // R8: locate on code
  p_loc_on_r8: assert property (@(posedge clk) disable iff (rst)
    (xmit_word[TOP-3 -: 2] == 2'd1) |=> led_loc[0]);
endmodule

bind drive_led_blinker drive_led_blinker_chk #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .blink_wr  (blink_wr),
  .xmit_word (xmit_word),
  .led_act   (led_act),
  .led_loc   (led_loc),
  .led_err   (led_err)
);

// File: tb/drive_led_blinker_tb.sv
module drive_led_blinker_tb;
  localparam int DIV = 4;

  typedef struct {
    int          due;
    logic [11:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  blink_rates = '0;
  logic        blink_wr = 1'b0;
  logic [31:0] xmit_word = '0;
  logic [3:0]  led_act, led_loc, led_err;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  drive_led_blinker #(.SUB_TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .blink_rates(blink_rates), .blink_wr(blink_wr),
    .xmit_word(xmit_word), .led_act(led_act), .led_loc(led_loc), .led_err(led_err)
  );

  function automatic logic ae(input logic [2:0] m, input logic pa, input logic pb);
    case (m)
      3'd1: return 1'b1;
      3'd2: return !pa;
      3'd3: return pa;
      3'd6: return !pb;
      3'd7: return pb;
      default: return 1'b0;
    endcase
  endfunction

  // expected {act[3:0], loc[3:0], err[3:0]}
  function automatic logic [11:0] model(input logic [31:0] w, input logic pa, input logic pb);
    logic [3:0] a, l, e;
    for (int d = 0; d < 4; d++) begin
      logic [7:0] b;
      b = w[8*(3-d) +: 8];
      a[d] = ae(b[7:5], pa, pb);
      e[d] = ae(b[2:0], pa, pb);
      case (b[4:3])
        2'd1: l[d] = 1'b1;
        2'd2: l[d] = !pa;
        2'd3: l[d] = pa;
        default: l[d] = 1'b0;
      endcase
    end
    return {a, l, e};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard items when they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      check(it.req, int'({led_act, led_loc, led_err}), int'(it.exp));
    end
  end

  task automatic apply(input logic [31:0] w, input logic pa, input logic pb, input string req);
    item_t it;
    xmit_word = w;
    it.due = cyc + 1;
    it.exp = model(w, pa, pb);
    it.req = req;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic write_rates(input logic [3:0] ra, input logic [3:0] rb);
    blink_rates = {rb, ra};
    blink_wr = 1'b1;
    @(negedge clk);
    blink_wr = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic pick(input int which);
    return (which == 1) ? led_act[1] : led_act[0];
  endfunction

  task automatic half_len(input int which, output int len);
    logic prev;
    int   n;
    prev = pick(which);
    n = 0;
    do begin @(negedge clk); n++; end while (pick(which) == prev && n < 1000);
    prev = pick(which);
    len = 0;
    do begin @(negedge clk); len++; end while (pick(which) == prev && len < 1000);
  endtask

  task automatic period_case(input int which, input int rate, input string req);
    int h1, h2;
    half_len(which, h1);
    h2 = 0;
    begin
      logic prev;
      prev = pick(which);
      do begin @(negedge clk); h2++; end while (pick(which) == prev && h2 < 1000);
    end
    check(req, h1, (rate + 1) * DIV);
    check(req, h2, (rate + 1) * DIV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    xmit_word = 32'h2929_2929;
    repeat (3) @(negedge clk);
    // R10: outputs dark during reset
    check("R10 reset", int'({led_act, led_loc, led_err}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 R5 R6 R7 R8 R11: every code on every drive, sources in first half
    for (int d = 0; d < 4; d++) begin
      write_rates(4'd15, 4'd15);
      for (int m = 0; m < 8; m++) begin
        logic [7:0] b;
        b = {m[2:0], m[1:0], m[2:0]};
        apply(32'(b) << (8*(3-d)), 1'b0, 1'b0, "R3/R4/R5/R6/R7/R8/R11 mode sweep");
      end
    end
    @(negedge clk);

    // R1: rate 0, 7, 15 on source A via drive 0 lit-first
    xmit_word = 32'h4000_0000;
    write_rates(4'd0, 4'd0);
    period_case(0, 0, "R1 rate0");
    write_rates(4'd7, 4'd0);
    period_case(0, 7, "R1 rate7");
    write_rates(4'd15, 4'd0);
    period_case(0, 15, "R1 rate15");

    // R2 R6: A and B at different rates, B on drive 1 mode 6
    xmit_word = 32'h40C0_0000;
    write_rates(4'd2, 4'd9);
    period_case(1, 9, "R2/R6 source B rate9");
    period_case(0, 2, "R2 source A rate2");

    // R9: restart from the dark half
    xmit_word = 32'h4000_0000;
    write_rates(4'd15, 4'd15);
    while (led_act[0] !== 1'b0) @(negedge clk);
    begin
      item_t it;
      blink_rates = 8'hFF;
      blink_wr = 1'b1;
      it.due = cyc + 2;
      it.exp = model(32'h4000_0000, 1'b0, 1'b0);
      it.req = "R9 restart";
      sb.push_back(it);
      @(negedge clk);
      blink_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end

    // R4 R8 then R10: all lamps on, then reset mid-run
    apply(32'h2929_2929, 1'b0, 1'b0, "R4/R8 all steady on");
    begin
      item_t it;
      rst = 1'b1;
      it.due = cyc + 1;
      it.exp = '0;
      it.req = "R10 reset mid-run";
      sb.push_back(it);
      @(negedge clk);
      @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule